// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Interrupts

This block sits between a register bus and a serial audio engine. It holds outgoing samples in one FIFO and incoming samples in a second FIFO. Each FIFO is eight 32-bit words deep. Software or a single-word DMA engine writes outgoing samples to a write-data register and reads incoming samples from a read-data register. On the other side, the serializer draws outgoing words and delivers incoming words through valid/ready streams.

A level register reports how full each FIFO is. Two DMA request lines follow programmable 4-bit thresholds. The threshold, underrun, overrun and fault events of each direction are latched in a status byte. Software clears a status bit by writing a one to it. Status bits selected by an enable byte drive one interrupt line. Nothing moves unless both the global enable and the DMA enable are set. A control write that clears the global enable returns the control state to its reset values and empties both FIFOs.

Stream rules: on the transmit stream, the block drives `tx_valid` while running with data queued, and a word moves in a cycle where `tx_valid` and `tx_ready` are both high. If the serializer raises `tx_ready` while the queue is empty, that counts as an underrun, and the block shows zero on `tx_data`. On the receive stream, the block drives `rx_ready` while running with space free. A word offered while `rx_ready` is low is dropped and flagged as an overrun, so the serializer may keep `rx_valid` high without waiting.

Top module: `aud_fifo_pair`

Register map (3-bit word address): 0 control, 1 status, 2 interrupt enable, 3 level, 4 transmit data, 5 receive data. Every register read returns its value on `reg_rdata` in the cycle after `reg_rd`.

## Requirements
- R1: After reset, control reads 0x00004040 and status, interrupt enable and level read 0. `irq`, both DMA requests, `tx_valid` and `rx_ready` are low.
- R2: Words written to address 4 while running leave on the transmit stream in write order. `tx_valid` is high exactly while the block is running and the transmit FIFO holds data.
- R3: Words accepted on the receive stream are returned in arrival order by reads of address 5. Each word appears on `reg_rdata` the cycle after `reg_rd`.
- R4: The level register holds the transmit fill count in bits 3:0 and the receive fill count in bits 7:4, saturating at 15, with all other bits 0. Writes to it have no effect.
- R5: A write to address 4 with 8 words queued drops the word and sets status bit 2. A receive word offered while the receive FIFO is full sees `rx_ready` low, is dropped, and sets status bit 6.
- R6: `tx_ready` high while running with the transmit FIFO empty sets status bit 1 and shows 0 on `tx_data`. A read of address 5 with the receive FIFO empty returns 0 and sets status bit 5.
- R7: A write to address 4 while not running sets status bit 3. A read of address 5 while not running returns 0 and sets status bit 7. Neither access changes either FIFO.
- R8: `tx_dma_req` is high while running and (8 − transmit count) exceeds the transmit threshold in control bits 7:4. `rx_dma_req` is high while running and the receive count is nonzero and at least the receive threshold in control bits 15:12.
- R9: Status bit 0 is set in every cycle in which `tx_dma_req` is high. Status bit 4 is set in every cycle in which `rx_dma_req` is high.
- R10: Writing a 1 to a status bit clears it and writing 0 leaves it unchanged. An event in the same cycle as the clear keeps the bit set.
- R11: `irq` is high exactly when some status bit and the same bit of the interrupt-enable byte (address 2, bits 7:0) are both set.
- R12: A control write with bit 31 clear makes control read 0x00004040 and interrupt enable read 0, and empties both FIFOs. Status keeps its value.
- R13: The block runs only while control bit 31 (global enable) and bit 30 (DMA enable) are both set. Otherwise `tx_valid`, `rx_ready` and both DMA requests stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Masked status interrupt |
| tx_dma_req | output | 1 | Transmit single-word DMA request |
| rx_dma_req | output | 1 | Receive single-word DMA request |
| tx_valid | output | 1 | Transmit word available to the serializer |
| tx_ready | input | 1 | Serializer takes the transmit word |
| tx_data | output | 32 | Transmit word, zero when not valid |
| rx_valid | input | 1 | Serializer offers a receive word |
| rx_ready | output | 1 | Receive FIFO can accept a word |
| rx_data | input | 32 | Receive word |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, that `reg_addr` is stable while a strobe is high, and that the serializer inputs change only between clock edges. The stimulus drives every strobe and stream input on the falling edge and keeps each to a single cycle. Bus accesses and stream transfers are kept in separate cycles, so no FIFO sees a push and a pop at the same edge. The sweeps set the threshold and fill count for each point from a freshly emptied FIFO, which keeps every counted event and DMA request traceable to one known state.

// File: rtl/aud_fifo_pkg.sv
package aud_fifo_pkg;
  localparam int ADDR_W = 3;
  localparam int REG_W  = 32;
  localparam int THR_W  = 4;
  localparam int LVL_W  = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TXD   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RXD   = 3'd5;

  localparam int EN_POS     = 31;
  localparam int DMA_POS    = 30;
  localparam int RX_THR_POS = 12;
  localparam int TX_THR_POS = 4;

  // per-direction event nibble: bit3 fault, bit2 overrun, bit1 underrun, bit0 threshold
  typedef struct packed {
    logic fault;
    logic over;
    logic under;
    logic thr;
  } dir_ev_t;

  typedef struct packed {
    logic             en;
    logic             dma_en;
    logic [THR_W-1:0] rx_thr;
    logic [THR_W-1:0] tx_thr;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, dma_en: 1'b0, rx_thr: 4'd4, tx_thr: 4'd4};
endpackage

// File: rtl/aud_fifo_mem.sv
module aud_fifo_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic [WIDTH-1:0]               push_data,
  input  logic                           pop,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (count == $past(count)));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !flush) |=> (count == '0));
endmodule

// File: rtl/aud_fifo_csr.sv
module aud_fifo_csr
  import aud_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  dir_ev_t           tx_ev,
  input  dir_ev_t           rx_ev,
  output ctrl_t             ctrl,
  output logic [7:0]        status,
  output logic [7:0]        ien,
  output logic              irq,
  output logic              flush
);
  logic       wr_ctrl, wr_stat, wr_ien;
  logic [7:0] ev_set, ev_clr;

  assign wr_ctrl = wr && (addr == ADR_CTRL);
  assign wr_stat = wr && (addr == ADR_STAT);
  assign wr_ien  = wr && (addr == ADR_IEN);
  assign flush   = wr_ctrl && !wdata[EN_POS];
  assign ev_set  = {rx_ev, tx_ev};
  assign ev_clr  = wr_stat ? wdata[7:0] : 8'h00;
  assign irq     = |(status & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= CTRL_RST;
      ien  <= 8'h00;
    end else if (flush) begin
      ctrl <= CTRL_RST;
      ien  <= 8'h00;
    end else begin
      if (wr_ctrl) begin
        ctrl.en     <= wdata[EN_POS];
        ctrl.dma_en <= wdata[DMA_POS];
        ctrl.rx_thr <= wdata[RX_THR_POS +: THR_W];
        ctrl.tx_thr <= wdata[TX_THR_POS +: THR_W];
      end
      if (wr_ien) ien <= wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 8'h00;
    else        status <= (status & ~ev_clr) | ev_set;
  end

  // R10
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && ev_set == 8'h00) |=> ((status & $past(wdata[7:0])) == 8'h00));

  // R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status & $past(status)) == $past(status)));

  // R12
  disable_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wdata[EN_POS]) |=> (ctrl == CTRL_RST && ien == 8'h00));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 8'h00) |-> !irq);
endmodule

// File: rtl/aud_fifo_dreq.sv
module aud_fifo_dreq
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       running,
  input  logic [$clog2(DEPTH+1)-1:0] tx_count,
  input  logic [$clog2(DEPTH+1)-1:0] rx_count,
  input  logic [THR_W-1:0]           tx_thr,
  input  logic [THR_W-1:0]           rx_thr,
  output logic                       tx_req,
  output logic                       rx_req
);
  int tx_free;

  assign tx_free = DEPTH - int'(tx_count);
  assign tx_req  = running && (tx_free > int'(tx_thr));
  assign rx_req  = running && (rx_count != '0) && (int'(rx_count) >= int'(rx_thr));

  // R8
  tx_fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && $stable(tx_thr) && !$past(tx_req)
     && (tx_count >= $past(tx_count))) |-> !tx_req);

  // R8
  rx_fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && $stable(rx_thr) && $past(rx_req)
     && (rx_count >= $past(rx_count))) |-> rx_req);
endmodule

// File: rtl/aud_fifo_pair.sv
module aud_fifo_pair
  import aud_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int LVL_MAX = (1 << LVL_W) - 1;

  ctrl_t             ctrl;
  logic [7:0]        status, ien;
  logic              flush, running;
  logic              bus_txw, bus_rxr;
  logic [DATA_W-1:0] tx_head, rx_head;
  logic [CW-1:0]     tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  dir_ev_t           tx_ev, rx_ev;
  logic [REG_W-1:0]  rd_mux;
  logic [LVL_W-1:0]  tx_lvl, rx_lvl;

  function automatic logic [LVL_W-1:0] sat_level(input logic [CW-1:0] c);
    int v;
    v = int'(c);
    if (v > LVL_MAX) v = LVL_MAX;
    return LVL_W'(v);
  endfunction

  assign running = ctrl.en && ctrl.dma_en;
  assign bus_txw = reg_wr && (reg_addr == ADR_TXD);
  assign bus_rxr = reg_rd && (reg_addr == ADR_RXD);

  aud_fifo_csr u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .tx_ev  (tx_ev),
    .rx_ev  (rx_ev),
    .ctrl   (ctrl),
    .status (status),
    .ien    (ien),
    .irq    (irq),
    .flush  (flush)
  );

  aud_fifo_mem #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (bus_txw && running),
    .push_data (reg_wdata[DATA_W-1:0]),
    .pop       (running && tx_ready),
    .head      (tx_head),
    .count     (tx_count),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  aud_fifo_mem #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (running && rx_valid),
    .push_data (rx_data),
    .pop       (bus_rxr && running),
    .head      (rx_head),
    .count     (rx_count),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  aud_fifo_dreq #(.DEPTH(DEPTH)) u_dreq (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .tx_count (tx_count),
    .rx_count (rx_count),
    .tx_thr   (ctrl.tx_thr),
    .rx_thr   (ctrl.rx_thr),
    .tx_req   (tx_dma_req),
    .rx_req   (rx_dma_req)
  );

  assign tx_valid = running && !tx_empty;
  assign tx_data  = tx_valid ? tx_head : '0;
  assign rx_ready = running && !rx_full;

  assign tx_ev.thr   = tx_dma_req;
  assign tx_ev.under = running && tx_ready && tx_empty;
  assign tx_ev.over  = bus_txw && running && tx_full;
  assign tx_ev.fault = bus_txw && !running;

  assign rx_ev.thr   = rx_dma_req;
  assign rx_ev.under = bus_rxr && running && rx_empty;
  assign rx_ev.over  = running && rx_valid && rx_full;
  assign rx_ev.fault = bus_rxr && !running;

  assign tx_lvl = sat_level(tx_count);
  assign rx_lvl = sat_level(rx_count);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADR_CTRL: begin
        rd_mux[EN_POS]                  = ctrl.en;
        rd_mux[DMA_POS]                 = ctrl.dma_en;
        rd_mux[RX_THR_POS +: THR_W]     = ctrl.rx_thr;
        rd_mux[TX_THR_POS +: THR_W]     = ctrl.tx_thr;
      end
      ADR_STAT:  rd_mux[7:0] = status;
      ADR_IEN:   rd_mux[7:0] = ien;
      ADR_LEVEL: rd_mux[2*LVL_W-1:0] = {rx_lvl, tx_lvl};
      ADR_RXD:   if (running && !rx_empty) rd_mux[DATA_W-1:0] = rx_head;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R5
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rx_valid && !rx_ready) |=> status[6]);

  // R6
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tx_ready && !tx_valid) |=> status[1]);

  // R6
  tx_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> (tx_data == '0));

  // R7
  tx_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_txw && !running && !flush) |=> (status[3] && tx_count == $past(tx_count)));
endmodule

// File: tb/test_aud_fifo_pair.sv
module test_aud_fifo_pair;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq, tx_dma_req, rx_dma_req, tx_valid, rx_ready;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [31:0] tx_data;
  logic [31:0] rx_data = 32'h0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  aud_fifo_pair i_aud_fifo_pair (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cv(input bit en, input bit dma, input int rxt, input int txt);
    return {en, dma, 14'b0, 4'(rxt), 4'b0, 4'(txt), 4'b0};
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic tx_take(output logic v, output logic [31:0] d);
    @(negedge clk);
    tx_ready = 1'b1;
    v = tx_valid; d = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d, output logic r);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    r = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic restart(input logic [31:0] c);
    reg_write(3'd0, 32'h0);
    reg_write(3'd0, c);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s_before;
    logic        v, r;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tx_dma_req", {31'b0, tx_dma_req}, 32'h0);
    chk("R1 rx_dma_req", {31'b0, rx_dma_req}, 32'h0);
    chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 32'h0);
    reg_read(3'd0, d); chk("R1 ctrl", d, 32'h0000_4040);
    reg_read(3'd1, d); chk("R1 status", d, 32'h0);
    reg_read(3'd2, d); chk("R1 ien", d, 32'h0);
    reg_read(3'd3, d); chk("R1 level", d, 32'h0);

    // R7 data accesses while disabled
    reg_write(3'd4, 32'h1234_5678);
    reg_read(3'd5, d); chk("R7 rx read disabled", d, 32'h0);
    reg_read(3'd1, d); chk("R7 fault bits", d, 32'h0000_0088);
    reg_read(3'd3, d); chk("R7 level untouched", d, 32'h0);
    // R10 partial clear
    reg_write(3'd1, 32'h0000_0008);
    reg_read(3'd1, d); chk("R10 partial clear", d, 32'h0000_0080);
    reg_write(3'd1, 32'h0000_00FF);
    reg_read(3'd1, d); chk("R10 full clear", d, 32'h0);

    // R13 global enable without DMA enable is idle
    reg_write(3'd0, cv(1, 0, 4, 4));
    chk("R13 tx_valid idle", {31'b0, tx_valid}, 32'h0);
    chk("R13 rx_ready idle", {31'b0, rx_ready}, 32'h0);
    chk("R13 tx_dma_req idle", {31'b0, tx_dma_req}, 32'h0);
    reg_write(3'd4, 32'hDEAD_0001);
    reg_read(3'd1, d); chk("R13 fault when half enabled", d, 32'h0000_0008);
    reg_write(3'd1, 32'h0000_00FF);

    // R2/R5/R6 transmit path, TX threshold 15 keeps requests off
    restart(cv(1, 1, 4, 15));
    for (int i = 0; i < 8; i++) reg_write(3'd4, 32'hA500_0000 + 32'(i));
    reg_write(3'd4, 32'hBAD0_BAD0);
    reg_read(3'd3, d); chk("R5 tx level full", d, 32'h0000_0008);
    reg_read(3'd1, d); chk("R5 tx overrun bit", d, 32'h0000_0004);
    for (int i = 0; i < 8; i++) begin
      tx_take(v, d);
      chk("R2 tx_valid", {31'b0, v}, 32'h1);
      chk("R2 tx order", d, 32'hA500_0000 + 32'(i));
    end
    tx_take(v, d);
    chk("R6 tx_valid empty", {31'b0, v}, 32'h0);
    chk("R6 tx_data zero", d, 32'h0);
    reg_read(3'd1, d); chk("R6 tx underrun bit", d, 32'h0000_0006);
    reg_write(3'd1, 32'h0000_00FF);

    // R3/R5/R6 receive path, RX threshold 4
    for (int i = 0; i < 8; i++) begin
      rx_push(32'h5A00_0000 + 32'(i * 3), r);
      chk("R5 rx_ready with space", {31'b0, r}, 32'h1);
    end
    rx_push(32'hBAD1_BAD1, r);
    chk("R5 rx_ready full", {31'b0, r}, 32'h0);
    reg_read(3'd3, d); chk("R4 rx level full", d, 32'h0000_0080);
    reg_read(3'd1, d); chk("R5 rx overrun and R9 rx thr", d, 32'h0000_0050);
    for (int i = 0; i < 8; i++) begin
      reg_read(3'd5, d); chk("R3 rx order", d, 32'h5A00_0000 + 32'(i * 3));
    end
    reg_read(3'd5, d); chk("R6 rx empty read zero", d, 32'h0);
    reg_read(3'd1, d); chk("R6 rx underrun bit", d, 32'h0000_0070);
    reg_write(3'd1, 32'h0000_00FF);
    reg_read(3'd1, d); chk("R10 clear after rx", d, 32'h0);

    // R8/R4 transmit request sweep over threshold and fill
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k <= 8; k++) begin
        restart(cv(1, 1, 4, t));
        for (int j = 0; j < k; j++) reg_write(3'd4, 32'(j));
        chk("R8 tx_dma_req sweep", {31'b0, tx_dma_req}, {31'b0, ((8 - k) > t)});
        if (t == 0) begin
          reg_read(3'd3, d); chk("R4 tx level sweep", d, 32'(k));
        end
      end
    end

    // R8/R4 receive request sweep over threshold and fill
    for (int t = 0; t < 16; t++) begin
      for (int k = 0; k <= 8; k++) begin
        restart(cv(1, 1, t, 15));
        for (int j = 0; j < k; j++) rx_push(32'(j), r);
        chk("R8 rx_dma_req sweep", {31'b0, rx_dma_req}, {31'b0, (k >= t) && (k != 0)});
        if (t == 0) begin
          reg_read(3'd3, d); chk("R4 rx level sweep", d, 32'(k) << 4);
        end
      end
    end

    // R9/R10 threshold event with concurrent clear
    restart(cv(1, 1, 4, 4));
    reg_write(3'd1, 32'h0000_00FF);
    reg_read(3'd1, d); chk("R9 tx thr bit", d, 32'h0000_0001);
    reg_write(3'd1, 32'h0000_0001);
    reg_read(3'd1, d); chk("R10 event wins over clear", d, 32'h0000_0001);
    reg_write(3'd0, cv(1, 1, 4, 15));
    reg_write(3'd1, 32'h0000_0001);
    reg_read(3'd1, d); chk("R9 tx thr cleared when idle", d, 32'h0);

    // R11 interrupt masking
    reg_write(3'd2, 32'h0000_0002);
    tx_take(v, d);
    chk("R11 irq enabled", {31'b0, irq}, 32'h1);
    reg_write(3'd2, 32'h0);
    chk("R11 irq masked", {31'b0, irq}, 32'h0);
    reg_write(3'd2, 32'h0000_0002);
    chk("R11 irq unmasked", {31'b0, irq}, 32'h1);
    reg_write(3'd1, 32'h0000_0002);
    chk("R11 irq after clear", {31'b0, irq}, 32'h0);

    // R4 level is read-only
    reg_write(3'd4, 32'h1);
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd3, d); chk("R4 level write ignored", d, 32'h0000_0001);

    // R12 disable returns control state and empties FIFOs
    rx_push(32'h77, r);
    rx_push(32'h78, r);
    reg_write(3'd2, 32'h0000_0004);
    reg_read(3'd1, s_before);
    reg_write(3'd0, cv(0, 1, 7, 7));
    reg_read(3'd0, d); chk("R12 ctrl reset", d, 32'h0000_4040);
    reg_read(3'd2, d); chk("R12 ien reset", d, 32'h0);
    reg_read(3'd3, d); chk("R12 fifos emptied", d, 32'h0);
    reg_read(3'd1, d); chk("R12 status kept", d, s_before);
    reg_write(3'd0, cv(1, 1, 4, 15));
    chk("R12 tx empty after re-enable", {31'b0, tx_valid}, 32'h0);
    reg_read(3'd5, d); chk("R12 rx empty after re-enable", d, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule